// File: doc/BRIEF.md
# Integer Multiply-Divide Execution Unit

This unit performs the eight integer multiply and divide operations of a 32-bit RISC-V core's M group. An operation starts when `start_i` is sampled high while the unit is idle. The unit latches the operation code and both operands at that edge. It raises `busy_o` while it works, then returns a 32-bit result together with a single-cycle `done_o`. The result is held until the next operation finishes.

All four multiply variants share one two-stage datapath. The operands are sign- or zero-extended to 33 bits, and one signed 33x33 product is formed. The selected 32-bit half of that product is returned. Division uses a radix-2 restoring loop on the operand magnitudes, followed by a sign correction. A zero divisor and the signed overflow case are detected when the operation is accepted, and they return fixed values one cycle later. No case ever raises a trap or a flag.

Top module: `mdu_top`

## Requirements
- R1: `op_i` = 0 selects MUL, which returns bits 31..0 of the product. This low half is the same for signed and unsigned readings of the operands.
- R2: `op_i` = 1 selects MULH, which returns bits 63..32 of the product with both operands signed. 0x80000000 times 0x80000000 gives 0x40000000.
- R3: `op_i` = 3 selects MULHU, which returns the upper 32 bits of the product with both operands unsigned.
- R4: `op_i` = 2 selects MULHSU, which returns the upper 32 bits with `a_i` signed and `b_i` unsigned. Swapping the operands changes the result: -1 by 2 gives 0xFFFFFFFF, while 2 by 0xFFFFFFFF gives 0x00000001.
- R5: `op_i` = 4 (DIV) and 5 (DIVU) return the quotient, signed and unsigned respectively. `op_i` = 6 (REM) and 7 (REMU) return the remainder. Signed quotients truncate toward zero, and a nonzero signed remainder takes the sign of `a_i`.
- R6: With `b_i` = 0, DIV and DIVU return 0xFFFFFFFF.
- R7: With `b_i` = 0, REM and REMU return `a_i` unchanged.
- R8: DIV of 0x80000000 by 0xFFFFFFFF returns 0x80000000, and REM of the same operands returns 0.
- R9: Let k be the edge that accepts a start. `done_o` is high in the cycle after edge k+2 for a multiply. It is high in the cycle after edge k for a division covered by R6, R7 or R8. For any other division it is high in the cycle after edge k+33.
- R10: `busy_o` is high from the edge after acceptance until the edge that raises `done_o`. A start seen while `busy_o` is high is ignored.
- R11: `done_o` lasts one cycle per operation. `result_o` changes only at the edge that raises `done_o`.
- R12: While `rst` is high, and after it is released, `busy_o` and `done_o` are low and `result_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request an operation; accepted only while idle |
| op_i | input | 3 | Operation code as listed in R1 to R5 |
| a_i | input | 32 | First operand (rs1 role) |
| b_i | input | 32 | Second operand (rs2 role) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | 32 | Result, held until the next completion |

## Verification
The assertions assume that the inputs are defined whenever `start_i` is high. They also assume that an accepted request means `start_i` is high while `busy_o` is low. The zero-divisor and overflow properties rely on the operands and `op_i` being stable at that edge. The stimulus changes inputs only on falling edges, and it draws operands from a pool of corner values: zero, one, all ones, the most negative and most positive values, and random words. Starts are issued at random, including while the unit is busy. This exercises the ignored-request rule against a behavioural model that is compared every cycle.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    typedef enum logic [2:0] {
        OP_MUL    = 3'd0,
        OP_MULH   = 3'd1,
        OP_MULHSU = 3'd2,
        OP_MULHU  = 3'd3,
        OP_DIV    = 3'd4,
        OP_DIVU   = 3'd5,
        OP_REM    = 3'd6,
        OP_REMU   = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MUL,
        ST_DIV
    } st_e;

    // sign handling latched at acceptance for the divide path
    typedef struct packed {
        logic neg_q;
        logic neg_r;
        logic want_rem;
    } div_fix_t;

    function automatic logic op_is_div(op_e op);
        return op[2];
    endfunction

    function automatic logic mul_a_signed(op_e op);
        return (op == OP_MULH) || (op == OP_MULHSU);
    endfunction

    function automatic logic mul_b_signed(op_e op);
        return op == OP_MULH;
    endfunction

    function automatic logic mul_wants_high(op_e op);
        return op != OP_MUL;
    endfunction

    function automatic logic div_signed(op_e op);
        return !op[0];
    endfunction

    function automatic logic div_wants_rem(op_e op);
        return op[1];
    endfunction

endpackage

// File: rtl/mdu_mul.sv
module mdu_mul #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic            a_sgn,
    input  logic            b_sgn,
    input  logic            hi_sel,
    output logic            out_valid,
    output logic [XLEN-1:0] out_res
);
    localparam int EW = XLEN + 1;
    localparam int PW = 2 * EW;

    logic signed [EW-1:0] ea_q, eb_q;
    logic                 hi1_q, v1_q;
    logic signed [PW-1:0] prod_q;
    logic                 hi2_q, v2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ea_q   <= '0;
            eb_q   <= '0;
            hi1_q  <= 1'b0;
            v1_q   <= 1'b0;
            prod_q <= '0;
            hi2_q  <= 1'b0;
            v2_q   <= 1'b0;
        end else begin
            v1_q  <= in_valid;
            v2_q  <= v1_q;
            hi2_q <= hi1_q;
            if (in_valid) begin
                ea_q  <= {a_sgn & opa[XLEN-1], opa};
                eb_q  <= {b_sgn & opb[XLEN-1], opb};
                hi1_q <= hi_sel;
            end
            if (v1_q) begin
                prod_q <= $signed({{EW{ea_q[EW-1]}}, ea_q}) * $signed({{EW{eb_q[EW-1]}}, eb_q});
            end
        end
    end

    assign out_valid = v2_q;
    assign out_res   = hi2_q ? prod_q[2*XLEN-1:XLEN] : prod_q[XLEN-1:0];

endmodule

// File: rtl/mdu_div.sv
module mdu_div #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [XLEN-1:0] dividend,
    input  logic [XLEN-1:0] divisor,
    output logic            fin,
    output logic [XLEN-1:0] quo,
    output logic [XLEN-1:0] rem
);
    localparam int CW = $clog2(XLEN + 1);

    logic [XLEN-1:0] rem_q, quo_q, dvs_q;
    logic [CW-1:0]   cnt_q;
    logic            run_q, fin_q;
    logic [XLEN:0]   r_sh, diff;
    logic            fits;

    always_comb begin
        r_sh = {rem_q, quo_q[XLEN-1]};
        diff = r_sh - {1'b0, dvs_q};
        fits = !diff[XLEN];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            fin_q <= 1'b0;
        end else if (load) begin
            rem_q <= '0;
            quo_q <= dividend;
            dvs_q <= divisor;
            cnt_q <= CW'(XLEN);
            run_q <= 1'b1;
            fin_q <= 1'b0;
        end else if (run_q) begin
            rem_q <= fits ? diff[XLEN-1:0] : r_sh[XLEN-1:0];
            quo_q <= {quo_q[XLEN-2:0], fits};
            cnt_q <= cnt_q - CW'(1);
            if (cnt_q == CW'(1)) begin
                run_q <= 1'b0;
                fin_q <= 1'b1;
            end
        end else begin
            fin_q <= 1'b0;
        end
    end

    assign fin = fin_q;
    assign quo = quo_q;
    assign rem = rem_q;

endmodule

// File: rtl/mdu_top.sv
module mdu_top
    import mdu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic [2:0]      op_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic            busy_o,
    output logic            done_o,
    output logic [XLEN-1:0] result_o
);
    localparam logic [XLEN-1:0] MIN_V = {1'b1, {(XLEN-1){1'b0}}};
    localparam logic [XLEN-1:0] ONES  = '1;

    st_e             st_q;
    logic            done_q;
    logic [XLEN-1:0] res_q;
    div_fix_t        fix_q;

    op_e             op;
    logic            accept, is_div, sgn, b_zero, ovf, special;
    logic            a_neg, b_neg;
    logic [XLEN-1:0] spec_res, mag_a, mag_b;
    div_fix_t        fix_d;

    logic            mul_v, div_fin;
    logic [XLEN-1:0] mul_res, div_quo, div_rem, div_out;

    always_comb begin
        op       = op_e'(op_i);
        accept   = start_i && (st_q == ST_IDLE);
        is_div   = op_is_div(op);
        sgn      = div_signed(op);
        b_zero   = (b_i == '0);
        ovf      = sgn && (a_i == MIN_V) && (b_i == ONES);
        special  = is_div && (b_zero || ovf);
        if (b_zero)
            spec_res = div_wants_rem(op) ? a_i : ONES;
        else
            spec_res = div_wants_rem(op) ? '0 : MIN_V;
        a_neg          = sgn && a_i[XLEN-1];
        b_neg          = sgn && b_i[XLEN-1];
        mag_a          = a_neg ? (~a_i + 1'b1) : a_i;
        mag_b          = b_neg ? (~b_i + 1'b1) : b_i;
        fix_d.neg_q    = a_neg ^ b_neg;
        fix_d.neg_r    = a_neg;
        fix_d.want_rem = div_wants_rem(op);
    end

    mdu_mul #(.XLEN(XLEN)) u_mul (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (accept && !is_div),
        .opa       (a_i),
        .opb       (b_i),
        .a_sgn     (mul_a_signed(op)),
        .b_sgn     (mul_b_signed(op)),
        .hi_sel    (mul_wants_high(op)),
        .out_valid (mul_v),
        .out_res   (mul_res)
    );

    mdu_div #(.XLEN(XLEN)) u_div (
        .clk      (clk),
        .rst      (rst),
        .load     (accept && is_div && !special),
        .dividend (mag_a),
        .divisor  (mag_b),
        .fin      (div_fin),
        .quo      (div_quo),
        .rem      (div_rem)
    );

    always_comb begin
        if (fix_q.want_rem)
            div_out = fix_q.neg_r ? (~div_rem + 1'b1) : div_rem;
        else
            div_out = fix_q.neg_q ? (~div_quo + 1'b1) : div_quo;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b0;
            res_q  <= '0;
            fix_q  <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        fix_q <= fix_d;
                        if (!is_div) begin
                            st_q <= ST_MUL;
                        end else if (special) begin
                            res_q  <= spec_res;
                            done_q <= 1'b1;
                        end else begin
                            st_q <= ST_DIV;
                        end
                    end
                end
                ST_MUL: begin
                    if (mul_v) begin
                        res_q  <= mul_res;
                        done_q <= 1'b1;
                        st_q   <= ST_IDLE;
                    end
                end
                ST_DIV: begin
                    if (div_fin) begin
                        res_q  <= div_out;
                        done_q <= 1'b1;
                        st_q   <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o   = (st_q != ST_IDLE);
    assign done_o   = done_q;
    assign result_o = res_q;

endmodule

// File: rtl/mdu_chk.sv
module mdu_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            start_i,
    input logic [2:0]      op_i,
    input logic [XLEN-1:0] a_i,
    input logic [XLEN-1:0] b_i,
    input logic            busy_o,
    input logic            done_o,
    input logic [XLEN-1:0] result_o
);
    localparam logic [XLEN-1:0] MIN_V = {1'b1, {(XLEN-1){1'b0}}};

    logic acc;
    assign acc = start_i && !busy_o;

    AST_QUO_BY_ZERO: assert property (@(posedge clk) disable iff (rst)
        (acc && op_i[2:1] == 2'b10 && b_i == '0) |=> (done_o && result_o == '1)); // R6

    AST_REM_BY_ZERO: assert property (@(posedge clk) disable iff (rst)
        (acc && op_i[2:1] == 2'b11 && b_i == '0) |=> (done_o && result_o == $past(a_i))); // R7

    AST_OVF_QUO: assert property (@(posedge clk) disable iff (rst)
        (acc && op_i == 3'd4 && a_i == MIN_V && b_i == '1) |=> (done_o && result_o == MIN_V)); // R8

    AST_OVF_REM: assert property (@(posedge clk) disable iff (rst)
        (acc && op_i == 3'd6 && a_i == MIN_V && b_i == '1) |=> (done_o && result_o == '0)); // R8

    AST_MUL_TAKES_CYCLES: assert property (@(posedge clk) disable iff (rst)
        (acc && !op_i[2]) |=> (busy_o && !done_o)); // R9

    AST_BUSY_NO_DONE: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> !done_o); // R10

    AST_BUSY_ENDS_IN_DONE: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> (busy_o || done_o)); // R10

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (done_o && !acc) |=> !done_o); // R11

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !done_o |=> (done_o || $stable(result_o))); // R11

endmodule

bind mdu_top mdu_chk #(.XLEN(XLEN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o)
);

// File: tb/tb_mdu_top.sv
module tb_mdu_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] MINV = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic        busy_o, done_o;
    logic [31:0] result_o;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdu_top dut (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
    );

    function automatic logic [31:0] ref_res(logic [2:0] op, logic [31:0] a, logic [31:0] b);
        logic [63:0] ea, eb, p;
        int sa, sb;
        if (!op[2]) begin
            ea = (op == 3'd1 || op == 3'd2) ? {{32{a[31]}}, a} : {32'b0, a};
            eb = (op == 3'd1) ? {{32{b[31]}}, b} : {32'b0, b};
            p  = ea * eb;
            return (op == 3'd0) ? p[31:0] : p[63:32];
        end
        if (b == 0) return op[1] ? a : 32'hFFFF_FFFF;
        if (!op[0] && a == MINV && b == 32'hFFFF_FFFF) return op[1] ? 32'h0 : MINV;
        if (!op[0]) begin
            sa = $signed(a);
            sb = $signed(b);
            return op[1] ? 32'(sa % sb) : 32'(sa / sb);
        end
        return op[1] ? (a % b) : (a / b);
    endfunction

    function automatic int lat_of(logic [2:0] op, logic [31:0] a, logic [31:0] b);
        if (!op[2]) return 2;
        if (b == 0) return 0;
        if (!op[0] && a == MINV && b == 32'hFFFF_FFFF) return 0;
        return 33;
    endfunction

    function automatic string tag_of(logic [2:0] op, logic [31:0] a, logic [31:0] b);
        case (op)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd3: return "R3";
            3'd2: return "R4";
            default: begin
                if (b == 0) return op[1] ? "R7" : "R6";
                if (!op[0] && a == MINV && b == 32'hFFFF_FFFF) return "R8";
                return "R5";
            end
        endcase
    endfunction

    // behavioural reference, advanced on every rising edge
    logic        busy_m = 0, done_m = 0;
    logic [31:0] res_m = 0, pend_m = 0;
    int          cnt_m = 0;
    string       tag_m = "R12", ptag_m = "R12";

    always @(posedge clk) begin
        if (rst) begin
            busy_m = 0; done_m = 0; res_m = 0; cnt_m = 0; tag_m = "R12";
        end else begin
            done_m = 0;
            if (busy_m) begin
                cnt_m--;
                if (cnt_m == 0) begin
                    res_m = pend_m; done_m = 1; busy_m = 0; tag_m = ptag_m;
                end
            end else if (start_i) begin
                pend_m = ref_res(op_i, a_i, b_i);
                ptag_m = tag_of(op_i, a_i, b_i);
                if (lat_of(op_i, a_i, b_i) == 0) begin
                    res_m = pend_m; done_m = 1; tag_m = ptag_m;
                end else begin
                    busy_m = 1; cnt_m = lat_of(op_i, a_i, b_i);
                end
            end
        end
    end

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare against the model on every falling edge
    always @(negedge clk) begin
        if (!rst && !ended) begin
            chk(busy_o == busy_m, "R10", 32'(busy_o), 32'(busy_m));
            chk(done_o == done_m, "R11", 32'(done_o), 32'(done_m));
            chk(result_o == res_m, tag_m, result_o, res_m);
        end
    end

    task automatic run_op(logic [2:0] op, logic [31:0] a, logic [31:0] b,
                          logic [31:0] exp, int exp_lat, string tag);
        int n;
        logic [31:0] held;
        while (busy_o) @(negedge clk);
        start_i = 1; op_i = op; a_i = a; b_i = b;
        n = 0;
        do begin
            @(negedge clk);
            start_i = 0;
            n++;
        end while (!done_o && n < 100);
        chk(result_o == exp, tag, result_o, exp);
        chk(n == exp_lat, "R9", 32'(n), 32'(exp_lat));
        held = result_o;
        @(negedge clk);
        chk(!done_o && result_o == held, "R11", result_o, held);
    endtask

    function automatic logic [31:0] pick();
        case ($urandom % 7)
            0: return 32'h0;
            1: return 32'h1;
            2: return 32'hFFFF_FFFF;
            3: return MINV;
            4: return 32'h7FFF_FFFF;
            5: return $urandom % 64;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && result_o == 0, "R12", result_o, 32'h0);
        rst = 0;
        @(negedge clk);
        chk(!busy_o && !done_o && result_o == 0, "R12", result_o, 32'h0);

        run_op(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1, 3, "R1");
        run_op(3'd1, MINV, MINV, 32'h4000_0000, 3, "R2");
        run_op(3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 3, "R3");
        run_op(3'd2, 32'hFFFF_FFFF, 32'h2, 32'hFFFF_FFFF, 3, "R4");
        run_op(3'd2, 32'h2, 32'hFFFF_FFFF, 32'h1, 3, "R4");
        run_op(3'd4, 32'hFFFF_FFF9, 32'h2, 32'hFFFF_FFFD, 34, "R5");
        run_op(3'd6, 32'hFFFF_FFF9, 32'h2, 32'hFFFF_FFFF, 34, "R5");
        run_op(3'd7, 32'd100, 32'd7, 32'd2, 34, "R5");
        run_op(3'd4, 32'd5, 32'h0, 32'hFFFF_FFFF, 1, "R6");
        run_op(3'd5, 32'd5, 32'h0, 32'hFFFF_FFFF, 1, "R6");
        run_op(3'd6, 32'hDEAD_BEEF, 32'h0, 32'hDEAD_BEEF, 1, "R7");
        run_op(3'd7, 32'h1234_5678, 32'h0, 32'h1234_5678, 1, "R7");
        run_op(3'd4, MINV, 32'hFFFF_FFFF, MINV, 1, "R8");
        run_op(3'd6, MINV, 32'hFFFF_FFFF, 32'h0, 1, "R8");

        // random traffic, including starts while busy that must be ignored (R10)
        for (int i = 0; i < 4000; i++) begin
            start_i = ($urandom % 3) == 0;
            op_i    = 3'($urandom);
            a_i     = pick();
            b_i     = pick();
            @(negedge clk);
        end
        start_i = 0;
        repeat (40) @(negedge clk);
        ended = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule